// File: doc/BRIEF.md
# Variable-Length Serial Register Port

This block is the slave side of a three-wire serial port. It gives a host controller access to a bank of twelve registers, and each register is between two and six bytes wide. The port uses a frame input (active low), a serial clock, one bidirectional data line (split here into an input, an output and an output enable) and an active-high abort input. Every access starts with an eight-bit command that picks the direction and the register. A data phase follows, and its length in bytes is fixed by the selected register. When the data phase ends, the port expects a new command at once, with or without a frame toggle.

The serial clock, frame, abort and data inputs are sampled by the block clock `clk_i`. That clock must run several times faster than the serial clock. Serial clock edges are found by comparing each sample with the previous one. Input data is taken on serial rising edges. Read data is changed after serial falling edges. Write data is collected in a staging shift register and is copied into the bank only when the last bit of the register's byte count arrives. A write that is cut short therefore leaves the register as it was.

Top module: `sio_regport`

## Requirements
- R1: After reset, `sdio_oe_o` is low and every register reads back as zero.
- R2: The command byte is sent most significant bit first. Bit 7 = 1 selects a read and 0 selects a write. Bits 3:0 give the register address. Bits 6:4 have no effect.
- R3: The data phase lasts a fixed number of bytes set by the address: 6 bytes for addresses 2, 3 and 4; 4 bytes for addresses 5 and 7; 3 bytes for address 6; 2 bytes for every other address.
- R4: Data bytes are sent most significant byte first, and each byte most significant bit first. A full write followed by a read of the same address returns the written value.
- R5: A register changes only when its last data bit has been received. A write cut short by the frame going high or by the abort input leaves the register unchanged.
- R6: While `io_reset_i` is high, `sdio_oe_o` is low and the cycle in progress is dropped. After the abort input is released, the next eight rising serial edges form a command, even if the frame stayed low the whole time.
- R7: During a read data phase, `sdio_oe_o` goes high from the first falling serial edge after the eighth command bit. It drops after the last data bit and at any time the frame is high. It is never high outside a read data phase.
- R8: Addresses 12 to 15 act as 2-byte placeholders: writes to them are discarded and reads from them return zero.
- R9: While `cs_i` is high, serial clock edges have no effect and the bit counter stays at the start of a command.
- R10: When a data phase is complete and the frame is still low, the next eight rising serial edges are taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| io_reset_i | input | 1 | Aborts the current cycle, active high |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data to the host |
| sdio_oe_o | output | 1 | Drive enable for the shared data line |

## Verification
The hardest situation to reach is an abort in the middle of a data phase while the frame stays low. Reaching it needs a command, part of a data phase, a pulse on the abort input while the serial clock is low, and then a full new access. The bench runs this once during a read, to check that the drive is released at once, and once during a write, to check that the target keeps its old contents. In both runs the frame is never raised, so only the abort input can have restored command framing. The back-to-back test does the same for command boundaries: it chains a 6-byte write with a 3-byte read inside one frame, and a wrong byte count would misalign the second command.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;
  localparam int NUM_REGS  = 12;
  localparam int MAX_BYTES = 6;
  localparam int ADDR_W    = 4;

  // Data-phase length in bytes per address; unused addresses act as 2-byte dummies
  function automatic int unsigned reg_bytes(input logic [ADDR_W-1:0] a);
    case (a)
      4'd2, 4'd3, 4'd4: return 6;
      4'd5, 4'd7:       return 4;
      4'd6:             return 3;
      default:          return 2;
    endcase
  endfunction
endpackage

// File: rtl/sio_regport_edge.sv
module sio_regport_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/sio_regport_regfile.sv
module sio_regport_regfile
  import sio_regport_pkg::*;
#(
  parameter int NREG  = NUM_REGS,
  parameter int MAXB  = MAX_BYTES,
  parameter int AW    = ADDR_W,
  localparam int DW   = MAXB * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  output logic [NREG*DW-1:0] rd_bus_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int W = int'(reg_bytes(AW'(i))) * 8;
    logic [W-1:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              r_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))  r_q <= wr_data_i[W-1:0];
    end

    assign rd_bus_o[i*DW +: DW] = DW'(r_q);
  end
endmodule

// File: rtl/sio_regport_ctrl.sv
module sio_regport_ctrl
  import sio_regport_pkg::*;
#(
  parameter int NREG   = NUM_REGS,
  parameter int MAXB   = MAX_BYTES,
  parameter int AW     = ADDR_W,
  localparam int DW    = MAXB * 8,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               io_reset_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sdio_i,
  input  logic [NREG*DW-1:0] rd_bus_i,
  output logic               wr_en_o,
  output logic [AW-1:0]      wr_addr_o,
  output logic [DW-1:0]      wr_data_o,
  output logic               sdio_o,
  output logic               oe_o,
  output logic               in_data_o,
  output logic               is_read_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic [CNT_W-1:0]   total_o
);
  logic             in_data_q, is_read_q, rd_flag_q, sdio_q, oe_q;
  logic [AW-1:0]    addr_q;
  logic [AW-2:0]    addr_sh_q;   // bits 6:4 pass through and drop out
  logic [CNT_W-1:0] bit_cnt_q, total_q;
  logic [DW-2:0]    rx_sh_q;
  logic [DW-1:0]    tx_sh_q;

  logic [AW-1:0]    next_addr;
  int unsigned      next_bytes;
  logic [DW-1:0]    rd_sel, rd_aligned;
  logic             last_bit, active;

  assign active     = ~cs_i & ~io_reset_i;
  assign next_addr  = {addr_sh_q, sdio_i};
  assign next_bytes = reg_bytes(next_addr);
  assign last_bit   = in_data_q && (bit_cnt_q == total_q - 1'b1);

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NREG; i++)
      if (next_addr == AW'(i)) rd_sel = rd_bus_i[i*DW +: DW];
    rd_aligned = rd_sel << (DW - int'(next_bytes) * 8);
  end

  assign wr_data_o = {rx_sh_q, sdio_i};
  assign wr_addr_o = addr_q;
  assign wr_en_o   = active && rise_i && last_bit && !is_read_q && (addr_q < AW'(NREG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q <= 1'b0;  is_read_q <= 1'b0;  rd_flag_q <= 1'b0;
      sdio_q    <= 1'b0;  oe_q      <= 1'b0;  addr_q    <= '0;
      addr_sh_q <= '0;    bit_cnt_q <= '0;    total_q   <= '0;
      rx_sh_q   <= '0;    tx_sh_q   <= '0;
    end else if (!active) begin
      in_data_q <= 1'b0;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (rise_i) begin
      if (!in_data_q) begin
        if (bit_cnt_q == '0) rd_flag_q <= sdio_i;
        if (bit_cnt_q == CNT_W'(7)) begin
          in_data_q <= 1'b1;
          is_read_q <= rd_flag_q;
          addr_q    <= next_addr;
          total_q   <= CNT_W'(next_bytes * 8);
          tx_sh_q   <= rd_aligned;
          bit_cnt_q <= '0;
        end else begin
          addr_sh_q <= next_addr[AW-2:0];
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end else begin
        rx_sh_q <= wr_data_o[DW-2:0];
        if (last_bit) begin
          in_data_q <= 1'b0;
          bit_cnt_q <= '0;
          oe_q      <= 1'b0;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end else if (fall_i && in_data_q && is_read_q) begin
      sdio_q  <= tx_sh_q[DW-1];
      tx_sh_q <= tx_sh_q << 1;
      oe_q    <= 1'b1;
    end
  end

  assign sdio_o    = sdio_q;
  assign oe_o      = oe_q;
  assign in_data_o = in_data_q;
  assign is_read_o = is_read_q;
  assign bit_cnt_o = bit_cnt_q;
  assign total_o   = total_q;
endmodule

// File: rtl/sio_regport.sv
module sio_regport
  import sio_regport_pkg::*;
#(
  parameter int NREG   = NUM_REGS,
  parameter int MAXB   = MAX_BYTES,
  parameter int AW     = ADDR_W,
  localparam int DW    = MAXB * 8,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic io_reset_i,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o
);
  logic               rise, fall, wr_en, oe_raw, in_data, is_read;
  logic [AW-1:0]      wr_addr;
  logic [DW-1:0]      wr_data;
  logic [NREG*DW-1:0] rd_bus;
  logic [CNT_W-1:0]   bit_cnt, total_bits;

  sio_regport_edge u_edge (
    .clk_i, .rst_ni, .sclk_i, .rise_o(rise), .fall_o(fall)
  );

  sio_regport_ctrl #(.NREG(NREG), .MAXB(MAXB), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .cs_i, .io_reset_i,
    .rise_i(rise), .fall_i(fall), .sdio_i,
    .rd_bus_i(rd_bus), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdio_o, .oe_o(oe_raw), .in_data_o(in_data), .is_read_o(is_read),
    .bit_cnt_o(bit_cnt), .total_o(total_bits)
  );

  sio_regport_regfile #(.NREG(NREG), .MAXB(MAXB), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_bus_o(rd_bus)
  );

  // abort and frame release the line without waiting for a clock
  assign sdio_oe_o = oe_raw & ~cs_i & ~io_reset_i;
endmodule

// File: rtl/sio_regport_chk.sv
module sio_regport_chk #(
  parameter int NREG  = 12,
  parameter int DW    = 48,
  parameter int AW    = 4,
  parameter int CNT_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_i,
  input logic               io_reset_i,
  input logic               sdio_oe_o,
  input logic               in_data,
  input logic               is_read,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [CNT_W-1:0]   total_bits,
  input logic [NREG*DW-1:0] rd_bus
);
  assert_cs_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> (!in_data && bit_cnt == '0));

  assert_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_reset_i |=> (!in_data && bit_cnt == '0 && !sdio_oe_o));

  assert_oe_read_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> (in_data && is_read));

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data |-> (bit_cnt < total_bits));

  assert_instr_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_data |-> (bit_cnt < CNT_W'(8)));

  assert_commit_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(rd_bus));

  assert_dummy_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_addr < AW'(NREG)));
endmodule

bind sio_regport sio_regport_chk #(.NREG(NREG), .DW(DW), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cs_i, .io_reset_i, .sdio_oe_o,
  .in_data, .is_read, .wr_en, .wr_addr, .bit_cnt, .total_bits, .rd_bus
);

// File: tb/sio_regport_bench.sv
module sio_regport_bench;
  logic clk = 1'b0, rst_ni = 1'b0, cs = 1'b1, sclk = 1'b0, iorst = 1'b0, sdi = 1'b0;
  logic sdo, oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [47:0] model [16];

  always #5 clk = ~clk;

  sio_regport u_sio_regport (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sclk_i(sclk), .io_reset_i(iorst),
    .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(oe)
  );

  function automatic int nb(input int a);
    if (a >= 2 && a <= 4) return 6;
    if (a == 5 || a == 7) return 4;
    if (a == 6) return 3;
    return 2;
  endfunction

  function automatic logic [47:0] msk(input int a);
    logic [63:0] m = (64'd1 << (nb(a) * 8)) - 64'd1;
    return m[47:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic got, output logic oe_s);
    sclk = 1'b0; sdi = b; #40;
    got = sdo; oe_s = oe;
    sclk = 1'b1; #40;
  endtask

  // shift n bits of w (MSB first); returns received bits and count of drive-enabled samples
  task automatic bits(input int n, input logic [47:0] w, output logic [47:0] r, output int oe_n);
    logic g, e;
    r = '0; oe_n = 0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_x(w[i], g, e);
      r = {r[46:0], g};
      oe_n += int'(e);
    end
  endtask

  task automatic frame_on();  sclk = 1'b0; cs = 1'b0; #20; endtask
  task automatic frame_off(); sclk = 1'b0; #20; cs = 1'b1; #20; endtask

  task automatic access(input bit rd, input int a, input logic [2:0] junk,
                        input logic [47:0] w, output logic [47:0] r, output int oe_i, output int oe_d);
    logic [47:0] dummy;
    bits(8, {40'd0, rd, junk, 4'(a)}, dummy, oe_i);
    bits(nb(a) * 8, w, r, oe_d);
    if (!rd && a < 12) model[a] = w & msk(a);
  endtask

  task automatic full_write(input int a, input logic [47:0] w);
    logic [47:0] r; int oi, od;
    frame_on(); access(1'b0, a, 3'b000, w, r, oi, od); frame_off();
  endtask

  task automatic full_read(input int a, input string req);
    logic [47:0] r, exp; int oi, od;
    exp = (a < 12) ? model[a] : 48'd0;
    frame_on(); access(1'b1, a, 3'b000, '0, r, oi, od);
    check(r == exp, req, r, exp);
    check(oi == 0 && od == nb(a) * 8, "R7 oe window", 48'(od), 48'(nb(a) * 8));
    check(oe == 1'b0, "R7 oe off at end", 48'(oe), 48'd0);
    frame_off();
  endtask

  task automatic t_reset();
    check(oe == 1'b0, "R1 oe after reset", 48'(oe), 48'd0);
    for (int a = 0; a < 12; a++) full_read(a, "R1 reset value / R3 length");
  endtask

  task automatic t_roundtrip();
    for (int a = 0; a < 16; a++) full_write(a, 48'hA1B2_C3D4_E5F6 ^ (48'h0101_0101_0101 * a));
    for (int a = 0; a < 12; a++) full_read(a, "R4 roundtrip / R3 length");
    for (int a = 12; a < 16; a++) full_read(a, "R8 dummy reads zero");
  endtask

  task automatic t_ignored_bits();
    logic [47:0] r; int oi, od;
    frame_on(); access(1'b0, 5, 3'b111, 48'h0000_9C8B_7A69, r, oi, od); frame_off();
    frame_on(); access(1'b1, 5, 3'b101, '0, r, oi, od); frame_off();
    check(r == 48'h0000_9C8B_7A69, "R2 bits 6:4 ignored", r, 48'h0000_9C8B_7A69);
  endtask

  task automatic t_back_to_back();
    logic [47:0] r; int oi, od;
    frame_on();
    access(1'b0, 2, 3'b000, 48'h1122_3344_5566, r, oi, od);
    access(1'b0, 6, 3'b000, 48'h0000_00DE_ADBE, r, oi, od);
    access(1'b1, 2, 3'b000, '0, r, oi, od);
    check(r == 48'h1122_3344_5566, "R10 chained read of 6-byte reg", r, 48'h1122_3344_5566);
    access(1'b1, 6, 3'b000, '0, r, oi, od);
    check(r == 48'h0000_00DE_ADBE, "R10 R3 chained read of 3-byte reg", r, 48'h0000_00DE_ADBE);
    check(od == 24, "R3 three-byte drive count", 48'(od), 48'd24);
    frame_off();
  endtask

  task automatic t_partial_cs();
    logic [47:0] r; int oi;
    logic [47:0] old = model[3];
    frame_on();
    bits(8, 48'h03, r, oi);
    bits(23, 48'h7F_FFFF, r, oi);
    frame_off();
    full_read(3, "R5 frame abort keeps register");
    check(model[3] == old, "R5 model unchanged", model[3], old);
  endtask

  task automatic t_ioreset();
    logic [47:0] r, exp; int oi, od;
    frame_on();
    bits(8, 48'h84, r, oi);
    bits(5, '0, r, od);
    check(od == 5, "R7 drive during read", 48'(od), 48'd5);
    sclk = 1'b0; #20; iorst = 1'b1; #1;
    check(oe == 1'b0, "R6 oe drops at abort", 48'(oe), 48'd0);
    #19; iorst = 1'b0; #20;
    // frame still low: next 8 edges must be a command
    bits(8, 48'h00, r, oi);
    bits(9, 48'h1FF, r, oi);
    sclk = 1'b0; #20; iorst = 1'b1; #20; iorst = 1'b0; #20;
    access(1'b1, 0, 3'b000, '0, r, oi, od);
    exp = model[0];
    check(r == exp, "R6 R5 aborted write leaves reg, command reframed", r, exp);
    access(1'b0, 1, 3'b000, 48'h0000_0000_5AA5, r, oi, od);
    access(1'b1, 1, 3'b000, '0, r, oi, od);
    check(r == 48'h5AA5, "R6 access after abort", r, 48'h5AA5);
    frame_off();
  endtask

  task automatic t_cs_ignored();
    logic g, e; int oe_n = 0;
    cs = 1'b1;
    for (int i = 0; i < 20; i++) begin
      bit_x(i[0], g, e);
      oe_n += int'(e);
    end
    check(oe_n == 0, "R9 no drive while frame high", 48'(oe_n), 48'd0);
    full_read(0, "R9 edges with frame high ignored");
    full_read(7, "R9 later access intact");
  endtask

  initial begin
    for (int a = 0; a < 16; a++) model[a] = '0;
    #30 rst_ni = 1'b1; #20;
    t_reset();
    t_roundtrip();
    t_ignored_bits();
    t_back_to_back();
    t_partial_cs();
    t_ioreset();
    t_cs_ignored();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule